// File: doc/BRIEF.md
# Dual PS/2 Channel Register Front End

This block puts a small register file in front of two PS/2 channels, one for a keyboard and one for a mouse. Each channel has its own 256-byte address window. Address bit 8 selects the channel, and address bits [3:2] select a register within the window. Software reads an identifier, reads received bytes, reads and writes a control byte, and reads a status byte. A write to the transmit offset hands one byte to the device side of the channel. Both channels drive a single shared interrupt line.

On the device side, each channel presents a byte-wide interface:
- a one-cycle transmit strobe with the byte being sent;
- the head byte of the receive queue, with a pop strobe;
- a queue-empty flag;
- an interrupt level from the device.

Each channel also has a loopback mode. In loopback, a written byte is caught in a one-byte holding register and raises the channel interrupt, so software can test its own path without a device. A diagnostic mode lets the line-shadow status bits follow the line-direction control bits.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd`. Side effects such as popping a byte or clearing a flag take place at the next rising clock edge.

Top module: `ps2_dual_regs`

## Requirements
- R1: `bus_addr[8]` selects the channel: 0 is the keyboard and 1 is the mouse. `bus_addr[3:2]` selects the register. A read at offset 0x0 returns 0 for the keyboard and 1 for the mouse.
- R2: Offset 0x8 holds a control byte that reads back exactly as written. Its bits are: 0x01 enable, 0x02 loopback, 0x20 diagnostic, 0x40 data direction, 0x80 clock direction.
- R3: When loopback is set, a write to offset 0x4 does the following: it stores the byte, sets the channel's holding-full flag, and raises the channel interrupt flag at the next edge. No transmit strobe is issued.
- R4: When loopback is set, a read at offset 0x4 returns the held byte. At the next edge it clears both the holding-full flag and the channel interrupt flag. No pop strobe is issued.
- R5: When loopback is clear, a write to offset 0x4 raises that channel's transmit strobe for the access cycle, carrying the written byte.
- R6: When loopback is clear, a read at offset 0x4 returns the channel's device receive byte and raises that channel's pop strobe for the access cycle.
- R7: A status read (offset 0xC) returns bits 0x40 and 0x80 as 1. The exception is diagnostic mode: there, 0x40 reads 0 when data direction is 0, and 0x80 reads 0 when clock direction is 0.
- R8: Status bit 0x01 is the holding-full flag when loopback is set. Otherwise it is the inverse of the device queue-empty flag.
- R9: When loopback is clear, a channel interrupt flag takes its device interrupt level at each edge. Status bit 0x10 and the `irq` output are the OR of both channel flags.
- R10: Status bits 0x02, 0x04 and 0x08 read 0. Writes to offsets 0x0 and 0xC change no state.
- R11: A synchronous active-high reset clears the control bytes, the holding registers, the holding-full flags and the interrupt flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_addr | input | 9 | Byte address; bit 8 selects the channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| kbd_tx_stb | output | 1 | Keyboard transmit strobe |
| kbd_tx_byte | output | 8 | Keyboard transmit byte |
| kbd_rx_byte | input | 8 | Keyboard receive queue head |
| kbd_rx_empty | input | 1 | Keyboard queue empty |
| kbd_rx_pop | output | 1 | Keyboard queue pop strobe |
| kbd_dev_irq | input | 1 | Keyboard device interrupt level |
| mouse_tx_stb | output | 1 | Mouse transmit strobe |
| mouse_tx_byte | output | 8 | Mouse transmit byte |
| mouse_rx_byte | input | 8 | Mouse receive queue head |
| mouse_rx_empty | input | 1 | Mouse queue empty |
| mouse_rx_pop | output | 1 | Mouse queue pop strobe |
| mouse_dev_irq | input | 1 | Mouse device interrupt level |
| irq | output | 1 | Shared interrupt |

## Verification
The hardest state to reach is a channel switching loopback on or off while its interrupt flag or holding-full flag is set. In that case the flag's source changes from the bus to the device level, and the receive-not-empty bit changes from the holding flag to the queue. The random stimulus writes control bytes with loopback set about half the time. It interleaves those writes with loopback writes and reads on both channels, and toggles the device interrupt and queue-empty inputs every access. Directed cases cover a held byte, a loopback exit and a re-entry, and check the stale flag in each direction.

// File: rtl/ps2_dual_regs.sv
module ps2_dual_regs #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          kbd_tx_stb,
  output logic [7:0]    kbd_tx_byte,
  input  logic [7:0]    kbd_rx_byte,
  input  logic          kbd_rx_empty,
  output logic          kbd_rx_pop,
  input  logic          kbd_dev_irq,
  output logic          mouse_tx_stb,
  output logic [7:0]    mouse_tx_byte,
  input  logic [7:0]    mouse_rx_byte,
  input  logic          mouse_rx_empty,
  output logic          mouse_rx_pop,
  input  logic          mouse_dev_irq,
  output logic          irq
);
  localparam int CH_BIT = AW - 1;
  localparam logic [1:0] OFS_ID = 2'd0, OFS_DATA = 2'd1, OFS_CTRL = 2'd2, OFS_STAT = 2'd3;
  localparam int B_LOOP = 1, B_DIAG = 5, B_DDIR = 6, B_CDIR = 7;

  logic [7:0] ctrl_q [2];
  logic [7:0] hold_q [2];
  logic [1:0] full_q, irq_q;

  wire       ch   = bus_addr[CH_BIT];
  wire [1:0] rsel = bus_addr[3:2];

  logic [1:0] dev_irq, rx_empty, loop, wr_data, rd_data, wr_ctrl;
  logic [7:0] rx_byte [2];

  assign dev_irq    = {mouse_dev_irq, kbd_dev_irq};
  assign rx_empty   = {mouse_rx_empty, kbd_rx_empty};
  assign rx_byte[0] = kbd_rx_byte;
  assign rx_byte[1] = mouse_rx_byte;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign loop[c]    = ctrl_q[c][B_LOOP];
    assign wr_data[c] = bus_wr && (ch == c) && (rsel == OFS_DATA);
    assign rd_data[c] = bus_rd && (ch == c) && (rsel == OFS_DATA);
    assign wr_ctrl[c] = bus_wr && (ch == c) && (rsel == OFS_CTRL);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[c] <= '0;
        hold_q[c] <= '0;
        full_q[c] <= 1'b0;
        irq_q[c]  <= 1'b0;
      end else begin
        if (wr_ctrl[c]) ctrl_q[c] <= bus_wdata;
        if (loop[c]) begin
          if (wr_data[c]) begin
            hold_q[c] <= bus_wdata;
            full_q[c] <= 1'b1;
            irq_q[c]  <= 1'b1;
          end else if (rd_data[c]) begin
            full_q[c] <= 1'b0;
            irq_q[c]  <= 1'b0;
          end
        end else begin
          irq_q[c] <= dev_irq[c];
        end
      end
    end
  end

  assign kbd_tx_stb    = wr_data[0] && !loop[0];
  assign kbd_tx_byte   = bus_wdata;
  assign kbd_rx_pop    = rd_data[0] && !loop[0];
  assign mouse_tx_stb  = wr_data[1] && !loop[1];
  assign mouse_tx_byte = bus_wdata;
  assign mouse_rx_pop  = rd_data[1] && !loop[1];
  assign irq           = |irq_q;

  logic [7:0] stat;
  always_comb begin
    stat = 8'hC0;
    if (ctrl_q[ch][B_DIAG]) begin
      if (!ctrl_q[ch][B_DDIR]) stat[6] = 1'b0;
      if (!ctrl_q[ch][B_CDIR]) stat[7] = 1'b0;
    end
    stat[0] = loop[ch] ? full_q[ch] : !rx_empty[ch];
    stat[4] = |irq_q;
  end

  always_comb begin
    unique case (rsel)
      OFS_ID:   bus_rdata = {7'd0, ch};
      OFS_DATA: bus_rdata = loop[ch] ? hold_q[ch] : rx_byte[ch];
      OFS_CTRL: bus_rdata = ctrl_q[ch];
      default:  bus_rdata = stat;
    endcase
  end

  AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (rst) kbd_tx_stb |-> !ctrl_q[0][B_LOOP]); // R3
  AST_LOOP_SETS_IRQ: assert property (@(posedge clk) disable iff (rst) (bus_wr && !ch && rsel == OFS_DATA && ctrl_q[0][B_LOOP]) |=> (irq && full_q[0])); // R3
  AST_LOOP_READ_CLEARS: assert property (@(posedge clk) disable iff (rst) (bus_rd && ch && rsel == OFS_DATA && ctrl_q[1][B_LOOP]) |=> !full_q[1]); // R4
  AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst) (kbd_rx_pop || mouse_rx_pop) |-> (bus_rd && $onehot0({kbd_rx_pop, mouse_rx_pop}))); // R6
  AST_IRQ_FOLLOWS_DEV: assert property (@(posedge clk) disable iff (rst) !ctrl_q[1][B_LOOP] |=> (irq_q[1] == $past(mouse_dev_irq))); // R9
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (rst) !(bus_wr && rsel == OFS_CTRL) |=> $stable(ctrl_q[0]) && $stable(ctrl_q[1])); // R10
endmodule

// File: tb/sim_ps2_dual_regs.sv
module sim_ps2_dual_regs;
  logic clk = 0, rst = 1;
  logic bus_rd = 0, bus_wr = 0;
  logic [8:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic kbd_tx_stb, mouse_tx_stb, kbd_rx_pop, mouse_rx_pop, irq;
  logic [7:0] kbd_tx_byte, mouse_tx_byte;
  logic [7:0] kbd_rx_byte = 8'h11, mouse_rx_byte = 8'h22;
  logic kbd_rx_empty = 1, mouse_rx_empty = 1, kbd_dev_irq = 0, mouse_dev_irq = 0;

  always #2.5 clk = ~clk;

  ps2_dual_regs u0 (.*);

  int checks = 0, fails = 0;
  logic [7:0] m_ctrl [2], m_hold [2];
  logic m_full [2], m_irq [2];

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(int c);
    logic [7:0] s = 8'hC0;
    if (m_ctrl[c][5]) begin
      if (!m_ctrl[c][6]) s[6] = 0;
      if (!m_ctrl[c][7]) s[7] = 0;
    end
    s[0] = m_ctrl[c][1] ? m_full[c] : !(c ? mouse_rx_empty : kbd_rx_empty);
    s[4] = m_irq[0] | m_irq[1];
    return s;
  endfunction

  task automatic mreset();
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 0; m_hold[c] = 0; m_full[c] = 0; m_irq[c] = 0;
    end
  endtask

  // one bus access: drive at negedge, check combinational outputs, then update model after the edge
  task automatic access(bit wr, int c, int ofs, logic [7:0] d);
    logic lb;
    @(negedge clk);
    chk("R9 irq", {7'd0, irq}, {7'd0, m_irq[0] | m_irq[1]});
    bus_wr = wr; bus_rd = !wr; bus_addr = {c[0], 4'h0, ofs[1:0], 2'b00}; bus_wdata = d;
    #1;
    lb = m_ctrl[c][1];
    if (!wr) begin
      case (ofs)
        0: chk("R1 id", bus_rdata, c[7:0]);
        1: chk(lb ? "R4 loop read" : "R6 rx read", bus_rdata, lb ? m_hold[c] : (c ? mouse_rx_byte : kbd_rx_byte));
        2: chk("R2 ctrl", bus_rdata, m_ctrl[c]);
        default: chk("R7 R8 R10 status", bus_rdata, exp_stat(c));
      endcase
    end
    chk("R5 R3 tx strobes", {6'd0, mouse_tx_stb, kbd_tx_stb},
        {6'd0, wr && ofs == 1 && !lb && c == 1, wr && ofs == 1 && !lb && c == 0});
    chk("R6 R4 pops", {6'd0, mouse_rx_pop, kbd_rx_pop},
        {6'd0, !wr && ofs == 1 && !lb && c == 1, !wr && ofs == 1 && !lb && c == 0});
    if (wr && ofs == 1 && !lb) chk("R5 tx byte", c ? mouse_tx_byte : kbd_tx_byte, d);
    @(posedge clk);
    for (int k = 0; k < 2; k++)
      if (!m_ctrl[k][1]) m_irq[k] = k ? mouse_dev_irq : kbd_dev_irq;
    if (lb && ofs == 1) begin
      if (wr) begin m_hold[c] = d; m_full[c] = 1; m_irq[c] = 1; end
      else begin m_full[c] = 0; m_irq[c] = 0; end
    end
    if (wr && ofs == 2) m_ctrl[c] = d;
    #1; bus_wr = 0; bus_rd = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mreset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11 reset state
    access(0, 0, 2, 0); access(0, 1, 2, 0); access(0, 1, 3, 0);
    access(0, 0, 0, 0); access(0, 1, 0, 0);                        // R1
    // R3/R4 directed loopback with held byte, then exit with stale flag
    access(1, 0, 2, 8'h02); access(1, 0, 1, 8'hA5);
    access(0, 1, 3, 0);                                            // R9 combined bit from other channel
    access(1, 0, 0, 8'hFF); access(1, 0, 3, 8'hFF);                // R10 no effect
    access(0, 0, 3, 0); access(0, 0, 2, 0);
    access(1, 0, 2, 8'h00);                                        // leave loopback while full
    kbd_rx_empty = 0; access(0, 0, 3, 0);                          // R8 queue source
    access(1, 0, 2, 8'h02); access(0, 0, 3, 0); access(0, 0, 1, 0); access(0, 0, 3, 0);
    // R7 diag combos
    access(1, 1, 2, 8'h20); access(0, 1, 3, 0);
    access(1, 1, 2, 8'h60); access(0, 1, 3, 0);
    access(1, 1, 2, 8'hA0); access(0, 1, 3, 0);
    access(1, 1, 2, 8'h40); access(0, 1, 3, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int c = $urandom_range(0, 1);
      int op = $urandom_range(0, 9);
      kbd_dev_irq = $urandom_range(0, 1); mouse_dev_irq = $urandom_range(0, 1);
      kbd_rx_empty = $urandom_range(0, 1); mouse_rx_empty = $urandom_range(0, 1);
      kbd_rx_byte = $urandom; mouse_rx_byte = $urandom;
      case (op)
        0: access(1, c, 2, 8'($urandom));
        1, 2: access(1, c, 1, 8'($urandom));
        3, 4: access(0, c, 1, 0);
        5, 6: access(0, c, 3, 0);
        7: access(0, c, 2, 0);
        8: access(0, c, 0, 0);
        default: access(1, c, $urandom_range(0, 1) ? 3 : 0, 8'($urandom));
      endcase
    end
    // R11 reset mid-run
    @(negedge clk); rst = 1; kbd_dev_irq = 0; mouse_dev_irq = 0;
    @(posedge clk); #1 rst = 0; mreset();
    access(0, 0, 2, 0); access(0, 1, 2, 0); access(0, 0, 3, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule